// File: doc/BRIEF.md
# Fractional Rate Clock Enable Generator

This block divides a fast reference clock by a ratio that need not be an integer. It drives a divided level, `div_clk`, that toggles at the end of every half period, and a one-cycle pulse, `edge_stb`, that marks each toggle. Downstream logic can use the pulse as a clock enable, or use the level as a slow clock-like signal. Each half period lasts either `half_base` or `half_base + 1` reference ticks. A phase accumulator picks the long half periods so that the long-term average half period equals `half_base + frac_num / frac_den` exactly. The error on any single edge never exceeds one reference tick.

The three settings are plain input ports. They are read every cycle and must be held stable while the divider runs. To change them cleanly, hold the divider in reset. Reset is asserted asynchronously and must be released in step with the clock.

For example, a 12 MHz level from a reference whose tick is one time unit needs a half period of 41 + 2/3 units. The divider produces it from `half_base = 41`, `frac_num = 2` and `frac_den = 3`, which gives the repeating half periods 41, 42, 42. The fastest possible output toggles every tick, which is half the reference rate.

Top module: `frac_clk_en_gen`

## Requirements
- R1: While `rst_n` is low, `div_clk` and `edge_stb` are 0 and the phase accumulator is cleared to 0.
- R2: Each half period is computed as follows. Let `s = acc + frac_num`. The half period lasts `half_base + 1` ticks when `s >= frac_den`, and `half_base` ticks otherwise. When the half period ends, `acc` becomes `s - frac_den` or `s` respectively. With `half_base = 41` and `frac_num/frac_den = 2/3`, the half periods repeat as 41, 42, 42.
- R3: With `frac_num < frac_den`, the first half period after reset release is the short one, `half_base` ticks.
- R4: With `half_base = 4` and `frac_num/frac_den = 1/6`, the half periods repeat as 4, 4, 4, 4, 4, 5.
- R5: `frac_den = 0` selects integer division: every half period is `half_base` ticks, whatever `frac_num` is.
- R6: A fraction with `frac_num >= frac_den` is ignored: every half period is `half_base` ticks.
- R7: `half_base = 0` behaves as `half_base = 1`. With a half period of 1 and no fraction, `div_clk` toggles on every reference edge, which is half the reference rate.
- R8: Starting from reset, the first K half periods together last exactly `K*half_base + floor(K*frac_num/frac_den)` ticks.
- R9: Every half period is either `half_base` or `half_base + 1` ticks long, so no edge departs from its ideal place by more than one tick.
- R10: `edge_stb` is 1 in exactly those cycles in which `div_clk` shows a new level, and `div_clk` changes at no other time. The first change after reset goes to 1. It appears after the L-th rising clock edge following reset release, where L is the first half period length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| half_base | input | CNT_W | Integer part of the half period in ticks (0 treated as 1) |
| frac_num | input | ACC_W | Numerator of the fractional part of the half period |
| frac_den | input | ACC_W | Denominator of the fractional part; 0 means integer division |
| div_clk | output | 1 | Divided level, toggles at the end of every half period |
| edge_stb | output | 1 | One-cycle pulse in each cycle where `div_clk` takes a new level |

## Verification
A corrupted accumulator moves a long half period to the wrong place. Because the pattern repeats every `frac_den` half periods, the error shows at the ports within one pattern repeat, as an interval between strobes that differs from the value the ratio predicts. A counter fault shows up as a wrong strobe spacing at the very next toggle. A divergence between the level and the pulse is visible in the same cycle it happens. The directed runs therefore compare every strobe interval against a sequence computed from the ratio. They also sum the intervals against the exact long-term total.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  // Kind of half period chosen by the phase accumulator.
  typedef enum logic {
    HALF_SHORT = 1'b0,
    HALF_LONG  = 1'b1
  } half_kind_e;

  localparam int unsigned DEF_CNT_W = 16;
  localparam int unsigned DEF_ACC_W = 16;

endpackage

// File: rtl/fcg_cfg_sanitize.sv
// Normalises the divider settings: a zero base becomes one, and a fraction
// that is out of range (zero denominator or numerator not below it) is
// replaced by an empty fraction.
module fcg_cfg_sanitize #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned ACC_W = 16
) (
  input  logic [CNT_W-1:0] base_in,
  input  logic [ACC_W-1:0] num_in,
  input  logic [ACC_W-1:0] den_in,
  output logic [CNT_W-1:0] base_eff,
  output logic [ACC_W-1:0] num_eff,
  output logic [ACC_W-1:0] den_eff
);

  localparam logic [CNT_W-1:0] BASE_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [ACC_W-1:0] ACC_ZERO  = '0;

  logic frac_valid;

  always_comb begin
    frac_valid = (den_in != ACC_ZERO) && (num_in < den_in);
    base_eff   = (base_in == '0) ? BASE_ONE : base_in;
    num_eff    = frac_valid ? num_in : ACC_ZERO;
    den_eff    = frac_valid ? den_in : ACC_ZERO;
  end

endmodule

// File: rtl/fcg_phase_acc.sv
// Phase accumulator: decides whether the half period in progress is
// stretched by one tick, and steps its remainder when the half period ends.
module fcg_phase_acc
  import frac_div_pkg::*;
#(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [ACC_W-1:0] num,
  input  logic [ACC_W-1:0] den,
  output half_kind_e       half_kind,
  output logic [ACC_W-1:0] acc_level
);

  localparam int unsigned SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] rem;
  logic             carry;

  // Next-state logic
  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, num};
    rem   = sum - {1'b0, den};
    carry = (den != '0) && (sum >= {1'b0, den});
    acc_d = acc_q;
    if (advance) begin
      acc_d = carry ? rem[ACC_W-1:0] : sum[ACC_W-1:0];
    end
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (advance) begin
      acc_q <= acc_d;
    end
  end

  assign half_kind = carry ? HALF_LONG : HALF_SHORT;
  assign acc_level = acc_q;

endmodule

// File: rtl/fcg_half_timer.sv
// Counts reference ticks inside the current half period and flags its last tick.
module fcg_half_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] base,
  input  logic             stretch,
  output logic             last_tick
);

  localparam int unsigned LEN_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [LEN_W-1:0] half_len;
  logic [LEN_W-1:0] cnt_next_ext;

  // Next-state logic
  always_comb begin
    half_len     = {1'b0, base} + {{CNT_W{1'b0}}, stretch};
    cnt_next_ext = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    last_tick    = (cnt_next_ext == half_len);
    cnt_d        = last_tick ? '0 : cnt_next_ext[CNT_W-1:0];
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fcg_edge_out.sv
// Output stage: registered divided level and its toggle pulse, aligned so the
// pulse is high in the first cycle of each new level.
module fcg_edge_out (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic level,
  output logic pulse
);

  logic level_q;
  logic level_d;
  logic pulse_q;
  logic pulse_d;

  // Next-state logic
  always_comb begin
    level_d = flip ? ~level_q : level_q;
    pulse_d = flip;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      level_q <= level_d;
      pulse_q <= pulse_d;
    end
  end

  assign level = level_q;
  assign pulse = pulse_q;

endmodule

// File: rtl/frac_clk_en_gen.sv
// Fractional rate clock enable generator: half periods of base or base+1
// ticks, chosen by a phase accumulator, so the average is base + num/den.
module frac_clk_en_gen
  import frac_div_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned ACC_W = DEF_ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half_base,
  input  logic [ACC_W-1:0] frac_num,
  input  logic [ACC_W-1:0] frac_den,
  output logic             div_clk,
  output logic             edge_stb
);

  logic [CNT_W-1:0] base_eff;
  logic [ACC_W-1:0] num_eff;
  logic [ACC_W-1:0] den_eff;
  logic [ACC_W-1:0] acc_level;
  half_kind_e       half_kind;
  logic             stretch;
  logic             half_end;

  fcg_cfg_sanitize #(
    .CNT_W (CNT_W),
    .ACC_W (ACC_W)
  ) u_cfg (
    .base_in  (half_base),
    .num_in   (frac_num),
    .den_in   (frac_den),
    .base_eff (base_eff),
    .num_eff  (num_eff),
    .den_eff  (den_eff)
  );

  fcg_phase_acc #(
    .ACC_W (ACC_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (half_end),
    .num       (num_eff),
    .den       (den_eff),
    .half_kind (half_kind),
    .acc_level (acc_level)
  );

  assign stretch = (half_kind == HALF_LONG);

  fcg_half_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (base_eff),
    .stretch   (stretch),
    .last_tick (half_end)
  );

  fcg_edge_out u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .flip  (half_end),
    .level (div_clk),
    .pulse (edge_stb)
  );

endmodule

// File: rtl/fcg_checker.sv
// Property checker for frac_clk_en_gen, attached with bind.
module fcg_checker #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned ACC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] half_base,
  input logic [ACC_W-1:0] frac_num,
  input logic [ACC_W-1:0] frac_den,
  input logic             div_clk,
  input logic             edge_stb,
  input logic [ACC_W-1:0] acc_level
);

  localparam int unsigned GAP_W = CNT_W + 2;

  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] base_chk;
  logic             int_mode;

  assign base_chk = (half_base == '0) ? {{(GAP_W-1){1'b0}}, 1'b1}
                                      : {2'b00, half_base};
  assign int_mode = (frac_den == '0) || (frac_num >= frac_den);

  // Ticks since reset release or since the last strobe, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (edge_stb) begin
      gap_q <= {{(GAP_W-1){1'b0}}, 1'b1};
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!div_clk && !edge_stb && acc_level == '0)); // R1

  AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_den != '0 && frac_num < frac_den) |-> (acc_level < frac_den)); // R2

  AST_STB_MARKS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |-> (div_clk != $past(div_clk))); // R10

  AST_TOGGLE_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (div_clk != $past(div_clk)) |-> edge_stb); // R10

  AST_HALF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |-> (gap_q == base_chk || gap_q == base_chk + 1'b1)); // R9

  AST_INT_MODE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_stb && int_mode) |-> (gap_q == base_chk)); // R5

endmodule

bind frac_clk_en_gen fcg_checker #(
  .CNT_W (CNT_W),
  .ACC_W (ACC_W)
) u_fcg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .half_base (half_base),
  .frac_num  (frac_num),
  .frac_den  (frac_den),
  .div_clk   (div_clk),
  .edge_stb  (edge_stb),
  .acc_level (acc_level)
);

// File: tb/test_frac_clk_en_gen.sv
`timescale 1ns/1ps
module test_frac_clk_en_gen;

  localparam int CNT_W = 16;
  localparam int ACC_W = 16;
  localparam int MAXH  = 64;
  localparam int WDOG  = 150000;

  logic             clk;
  logic             rst_n;
  logic [CNT_W-1:0] half_base;
  logic [ACC_W-1:0] frac_num;
  logic [ACC_W-1:0] frac_den;
  logic             div_clk;
  logic             edge_stb;

  int checks;
  int failures;
  int cycles;
  int iv [MAXH];
  int lv [MAXH];
  int stray;

  frac_clk_en_gen #(.CNT_W(CNT_W), .ACC_W(ACC_W)) i_frac_clk_en_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_base (half_base),
    .frac_num  (frac_num),
    .frac_den  (frac_den),
    .div_clk   (div_clk),
    .edge_stb  (edge_stb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WDOG) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cycles, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Apply settings under reset, then release on a falling edge.
  task automatic start(input int b, input int n, input int d);
    @(negedge clk);
    rst_n     = 1'b0;
    half_base = CNT_W'(b);
    frac_num  = ACC_W'(n);
    frac_den  = ACC_W'(d);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Record the tick count of the next nh half periods and the level at each strobe.
  task automatic grab(input int nh);
    int gap;
    logic prev;
    stray = 0;
    prev  = div_clk;
    for (int h = 0; h < nh; h++) begin
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
        if (div_clk != prev && !edge_stb) stray++;
        prev = div_clk;
      end while (!edge_stb && gap < 100000);
      iv[h] = gap;
      lv[h] = int'(div_clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    half_base = 16'd1;
    frac_num  = 16'd0;
    frac_den  = 16'd0;
    repeat (2) @(negedge clk);
    chk(div_clk == 1'b0, "R1 div_clk in reset", int'(div_clk), 0);
    chk(edge_stb == 1'b0, "R1 edge_stb in reset", int'(edge_stb), 0);
    half_base = 16'd3;
    repeat (4) @(negedge clk);
    chk(div_clk == 1'b0 && edge_stb == 1'b0, "R1 outputs stay low in reset",
        int'({div_clk, edge_stb}), 0);
  endtask

  task automatic t_twelve;
    int bad;
    start(41, 2, 3);
    grab(12);
    chk(iv[0] == 41, "R3 first half short", iv[0], 41);
    bad = 0;
    for (int h = 0; h < 12; h++) begin
      if (iv[h] != ((h % 3 == 0) ? 41 : 42)) begin
        bad++;
        $display("FAIL R2 half %0d: actual=%0d expected=%0d", h, iv[h], (h % 3 == 0) ? 41 : 42);
      end
    end
    chk(bad == 0, "R2 pattern 41,42,42", bad, 0);
    bad = 0;
    for (int h = 0; h < 12; h++) if (lv[h] != ((h % 2 == 0) ? 1 : 0)) bad++;
    chk(bad == 0, "R10 level alternates starting high", bad, 0);
    chk(stray == 0, "R10 level changes only with strobe", stray, 0);
  endtask

  task automatic t_tenunit;
    int bad;
    start(4, 1, 6);
    grab(12);
    bad = 0;
    for (int h = 0; h < 12; h++) begin
      if (iv[h] != ((h % 6 == 5) ? 5 : 4)) begin
        bad++;
        $display("FAIL R4 half %0d: actual=%0d expected=%0d", h, iv[h], (h % 6 == 5) ? 5 : 4);
      end
    end
    chk(bad == 0, "R4 pattern 4,4,4,4,4,5", bad, 0);
  endtask

  task automatic t_average;
    int sum;
    int outside;
    start(7, 3, 8);
    grab(16);
    sum = 0;
    outside = 0;
    for (int h = 0; h < 16; h++) begin
      sum += iv[h];
      if (iv[h] != 7 && iv[h] != 8) outside++;
    end
    chk(sum == 118, "R8 total of 16 halves", sum, 118);
    chk(outside == 0, "R9 halves within base..base+1", outside, 0);
  endtask

  task automatic t_integer;
    int bad;
    start(5, 5, 0);
    grab(6);
    bad = 0;
    for (int h = 0; h < 6; h++) if (iv[h] != 5) bad++;
    chk(bad == 0, "R5 zero denominator gives integer division", bad, 0);
  endtask

  task automatic t_bad_frac;
    int bad;
    start(9, 3, 3);
    grab(6);
    bad = 0;
    for (int h = 0; h < 6; h++) if (iv[h] != 9) bad++;
    chk(bad == 0, "R6 num equal den ignored", bad, 0);
    start(9, 10, 3);
    grab(6);
    bad = 0;
    for (int h = 0; h < 6; h++) if (iv[h] != 9) bad++;
    chk(bad == 0, "R6 num above den ignored", bad, 0);
  endtask

  task automatic t_fastest;
    int bad;
    start(1, 0, 0);
    grab(8);
    bad = 0;
    for (int h = 0; h < 8; h++) if (iv[h] != 1 || lv[h] != ((h % 2 == 0) ? 1 : 0)) bad++;
    chk(bad == 0, "R7 base 1 toggles every tick", bad, 0);
    start(0, 0, 0);
    grab(8);
    bad = 0;
    for (int h = 0; h < 8; h++) if (iv[h] != 1) bad++;
    chk(bad == 0, "R7 base 0 acts as 1", bad, 0);
    start(1, 1, 2);
    grab(8);
    bad = 0;
    for (int h = 0; h < 8; h++) if (iv[h] != ((h % 2 == 0) ? 1 : 2)) bad++;
    chk(bad == 0, "R2 pattern 1,2 at top rate", bad, 0);
    chk(stray == 0, "R10 no level change without strobe", stray, 0);
  endtask

  initial begin
    checks    = 0;
    failures  = 0;
    cycles    = 0;
    rst_n     = 1'b1;
    half_base = '0;
    frac_num  = '0;
    frac_den  = '0;
    #1 rst_n  = 1'b0;
    t_reset();
    t_twelve();
    t_tenunit();
    t_average();
    t_integer();
    t_bad_frac();
    t_fastest();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule